// File: doc/BRIEF.md
# Endpoint Select and Conditional Push Controller

This per-core block runs a two-step protocol for moving cache lines through a central message router. A select command latches the line address of a local cache line in a private register. The next push or fetch command uses that latched address and then discards it, whether the command succeeds or fails. A push is offered to the router. The router answers later with a success or failure. On success the local source line is zeroed. On failure the line is left as it was, so software can retry the push.

A fetch registers the selected line, its queue identifier and the core identifier with the router. It also sets a pushable flag on that line. When the router later injects data, the injection is written only if the target line's flag is set. An accepted injection clears the flag, so unread data cannot be overwritten. A rejected injection leaves the data in the router. A context switch clears all flags and the latched address. A page migration clears only the latched address. An eviction clears the flag of the evicted line. While any push still waits for its router answer, a hold output blocks context switches and interrupts.

Top module: `ep_sel_ctrl`

## Requirements
- R1: After reset every registered output is low: done_valid, push_done_valid, zero_valid, inj_ack, inj_nack and wr_valid. hold_ctx is low and no address is latched.
- R2: cmd_op 2'b01 latches cmd_addr[PA_W-1:6] as the selected line. A push (cmd_op 2'b10) with a line selected and fewer than PEND_D pushes pending raises rtr_push_req in the same cycle, with rtr_push_line set to the selected line and rtr_push_qid set to cmd_qid. No done_valid follows it. cmd_op 2'b00 is ignored.
- R3: A push or a fetch (cmd_op 2'b11) with no line selected raises no router request. One cycle later it gives done_valid with done_code 1.
- R4: Every push or fetch clears the latched address, including those that fail. A second push with no new select therefore ends with done_code 1.
- R5: One cycle after rtr_push_rsp, push_done_valid rises for the oldest pending push. If rtr_push_ok was high, push_done_code is 0 and zero_valid rises with zero_line set to that push's line. Otherwise push_done_code is 2 and zero_valid stays low.
- R6: hold_ctx is high while at least one push waits for its router answer. When PEND_D pushes are pending, a further selected push raises no request and ends with done_code 3.
- R7: A selected fetch with rtr_fetch_room high raises rtr_fetch_req in the same cycle. It carries the selected line, cmd_qid and CORE_ID. One cycle later it gives done_code 0 and sets the line's pushable flag. With rtr_fetch_room low, the fetch raises no request, ends with done_code 2 and sets no flag.
- R8: The pushable flag is held per index line[IDX_W-1:0]. An injection whose line index has its flag set gives inj_ack, wr_valid, wr_line and wr_data one cycle later, and it clears the flag. A repeated injection to that line is then answered with inj_nack.
- R9: An injection to a line whose flag is clear is answered with inj_nack one cycle later. wr_valid stays low.
- R10: ctx_switch clears all flags and the latched address. page_migr clears only the latched address. evict_valid clears only the flag of evict_line.
- R11: Router answers are matched to pending pushes in issue order. Successive zero_line values follow the order in which the pushes were issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 01 select, 10 push, 11 fetch, 00 none |
| cmd_addr | input | PA_W | Physical address for select |
| cmd_qid | input | QID_W | Queue identifier for push/fetch |
| done_valid | output | 1 | Immediate command status valid |
| done_code | output | 2 | 0 ok, 1 no select, 2 router full, 3 local busy |
| rtr_push_req | output | 1 | Push offered to router |
| rtr_push_line | output | PA_W-6 | Line being pushed |
| rtr_push_qid | output | QID_W | Queue of the push |
| rtr_push_rsp | input | 1 | Router answer for oldest pending push |
| rtr_push_ok | input | 1 | Router accepted that push |
| push_done_valid | output | 1 | Push status valid |
| push_done_code | output | 2 | 0 ok, 2 router full |
| zero_valid | output | 1 | Zero the source line |
| zero_line | output | PA_W-6 | Line to zero |
| rtr_fetch_req | output | 1 | Fetch registration to router |
| rtr_fetch_line | output | PA_W-6 | Target line of fetch |
| rtr_fetch_qid | output | QID_W | Queue of fetch |
| rtr_fetch_core | output | CORE_W | Requesting core identifier |
| rtr_fetch_room | input | 1 | Router can register a request |
| inj_valid | input | 1 | Injection from router |
| inj_line | input | PA_W-6 | Injection target line |
| inj_data | input | DATA_W | Injected line data |
| inj_ack | output | 1 | Injection accepted |
| inj_nack | output | 1 | Injection rejected |
| wr_valid | output | 1 | Cache line write |
| wr_line | output | PA_W-6 | Line written |
| wr_data | output | DATA_W | Data written |
| ctx_switch | input | 1 | Context switch or thread migration |
| page_migr | input | 1 | Page migration |
| evict_valid | input | 1 | Line evicted |
| evict_line | input | PA_W-6 | Evicted line |
| hold_ctx | output | 1 | Pushes pending; block switches |

## Verification
The command sequence is exercised in several ways. Commands are sent with and without a preceding select, so a missing select can be told apart from an address that was consumed earlier. Ignored opcodes and a fetch refused for lack of router room are mixed into the sequence; these show that only a real select re-arms the latch. Four pushes fill the pending tracker, and a fifth is refused locally rather than sent to the router. The four router answers then show that the zeroed lines come back in issue order and are not mixed up. Injections are sent to a freshly fetched line, to an already consumed line, to a line whose fetch was refused and to lines whose flags were hit by an eviction, a page migration or a context switch. Together these separate the flag being held from it being cleared by each event.

// File: rtl/ep_sel_pkg.sv
package ep_sel_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_SEL   = 2'b01,
    OP_PUSH  = 2'b10,
    OP_FETCH = 2'b11
  } ep_op_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_NOSEL = 2'd1,
    ST_RFULL = 2'd2,
    ST_LBUSY = 2'd3
  } ep_st_e;
endpackage

// File: rtl/ep_rst_sync.sv
module ep_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= 2'b00;
    else        stg <= {stg[0], 1'b1};
  end

  assign rst_sync_n = stg[1];
endmodule

// File: rtl/ep_sel_latch.sv
module ep_sel_latch #(
  parameter int LA_W = 34
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [LA_W-1:0] set_line,
  input  logic            clr_en,
  output logic            vld,
  output logic [LA_W-1:0] line
);
  logic vld_nx;
  logic line_en;

  always_comb begin
    vld_nx  = vld;
    line_en = 1'b0;
    if (clr_en) begin
      vld_nx = 1'b0;
    end else if (set_en) begin
      vld_nx  = 1'b1;
      line_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      line <= '0;
    end else begin
      vld <= vld_nx;
      if (line_en) line <= set_line;
    end
  end
endmodule

// File: rtl/ep_pend_fifo.sv
module ep_pend_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_en,
  input  logic [W-1:0] push_data,
  input  logic         pop_en,
  output logic [W-1:0] pop_data,
  output logic         full,
  output logic         nonempty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;

  always_comb begin
    wr_ptr_nx = wr_ptr;
    rd_ptr_nx = rd_ptr;
    cnt_nx    = cnt;
    if (push_en) wr_ptr_nx = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    if (pop_en)  rd_ptr_nx = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    case ({push_en, pop_en})
      2'b10:   cnt_nx = cnt + 1'b1;
      2'b01:   cnt_nx = cnt - 1'b1;
      default: cnt_nx = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      cnt    <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push_en && (wr_ptr == PTR_W'(i))) mem[i] <= push_data;
    end
  end

  assign pop_data = mem[rd_ptr];
  assign full     = (cnt == CNT_W'(DEPTH));
  assign nonempty = (cnt != '0);
endmodule

// File: rtl/ep_flag_tab.sv
module ep_flag_tab #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             drop_a_en,
  input  logic [IDX_W-1:0] drop_a_idx,
  input  logic             drop_b_en,
  input  logic [IDX_W-1:0] drop_b_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_flag
);
  localparam int NL = 1 << IDX_W;

  logic [NL-1:0] flags, flags_nx;

  for (genvar g = 0; g < NL; g++) begin : g_ent
    logic drop_hit, set_hit;
    assign drop_hit = (drop_a_en && (drop_a_idx == IDX_W'(g))) ||
                      (drop_b_en && (drop_b_idx == IDX_W'(g)));
    assign set_hit  = set_en && (set_idx == IDX_W'(g));
    assign flags_nx[g] = clr_all  ? 1'b0 :
                         drop_hit ? 1'b0 :
                         set_hit  ? 1'b1 : flags[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_nx;
  end

  assign rd_flag = flags[rd_idx];
endmodule

// File: rtl/ep_sel_ctrl.sv
module ep_sel_ctrl
  import ep_sel_pkg::*;
#(
  parameter int PA_W    = 40,
  parameter int OFS_W   = 6,
  parameter int QID_W   = 4,
  parameter int CORE_W  = 4,
  parameter int CORE_ID = 5,
  parameter int DATA_W  = 512,
  parameter int IDX_W   = 4,
  parameter int PEND_D  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [PA_W-1:0]      cmd_addr,
  input  logic [QID_W-1:0]     cmd_qid,
  output logic                 done_valid,
  output logic [1:0]           done_code,
  output logic                 rtr_push_req,
  output logic [PA_W-OFS_W-1:0] rtr_push_line,
  output logic [QID_W-1:0]     rtr_push_qid,
  input  logic                 rtr_push_rsp,
  input  logic                 rtr_push_ok,
  output logic                 push_done_valid,
  output logic [1:0]           push_done_code,
  output logic                 zero_valid,
  output logic [PA_W-OFS_W-1:0] zero_line,
  output logic                 rtr_fetch_req,
  output logic [PA_W-OFS_W-1:0] rtr_fetch_line,
  output logic [QID_W-1:0]     rtr_fetch_qid,
  output logic [CORE_W-1:0]    rtr_fetch_core,
  input  logic                 rtr_fetch_room,
  input  logic                 inj_valid,
  input  logic [PA_W-OFS_W-1:0] inj_line,
  input  logic [DATA_W-1:0]    inj_data,
  output logic                 inj_ack,
  output logic                 inj_nack,
  output logic                 wr_valid,
  output logic [PA_W-OFS_W-1:0] wr_line,
  output logic [DATA_W-1:0]    wr_data,
  input  logic                 ctx_switch,
  input  logic                 page_migr,
  input  logic                 evict_valid,
  input  logic [PA_W-OFS_W-1:0] evict_line,
  output logic                 hold_ctx
);
  localparam int LA_W = PA_W - OFS_W;

  logic            rst_i_n;
  ep_op_e          op;
  logic            is_sel, is_push, is_fetch;
  logic            sel_vld;
  logic [LA_W-1:0] sel_line;
  logic            pend_full, pend_any;
  logic [LA_W-1:0] pend_head;
  logic            push_go, fetch_go, pop_go;
  logic            flag_rd, inj_hit, inj_blocked;

  logic            done_valid_nx;
  logic [1:0]      done_code_nx;
  logic            pd_code_ok;

  ep_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign op       = ep_op_e'(cmd_op);
  assign is_sel   = cmd_valid && (op == OP_SEL);
  assign is_push  = cmd_valid && (op == OP_PUSH);
  assign is_fetch = cmd_valid && (op == OP_FETCH);

  ep_sel_latch #(.LA_W(LA_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .set_en   (is_sel),
    .set_line (cmd_addr[PA_W-1:OFS_W]),
    .clr_en   (is_push || is_fetch || ctx_switch || page_migr),
    .vld      (sel_vld),
    .line     (sel_line)
  );

  assign push_go  = is_push && sel_vld && !pend_full;
  assign fetch_go = is_fetch && sel_vld && rtr_fetch_room;
  assign pop_go   = rtr_push_rsp && pend_any;

  ep_pend_fifo #(.W(LA_W), .DEPTH(PEND_D)) u_pend (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .push_en   (push_go),
    .push_data (sel_line),
    .pop_en    (pop_go),
    .pop_data  (pend_head),
    .full      (pend_full),
    .nonempty  (pend_any)
  );

  assign inj_blocked = ctx_switch ||
                       (evict_valid && (evict_line[IDX_W-1:0] == inj_line[IDX_W-1:0]));
  assign inj_hit     = inj_valid && flag_rd && !inj_blocked;

  ep_flag_tab #(.IDX_W(IDX_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .clr_all    (ctx_switch),
    .set_en     (fetch_go),
    .set_idx    (sel_line[IDX_W-1:0]),
    .drop_a_en  (evict_valid),
    .drop_a_idx (evict_line[IDX_W-1:0]),
    .drop_b_en  (inj_hit),
    .drop_b_idx (inj_line[IDX_W-1:0]),
    .rd_idx     (inj_line[IDX_W-1:0]),
    .rd_flag    (flag_rd)
  );

  assign rtr_push_req   = push_go;
  assign rtr_push_line  = sel_line;
  assign rtr_push_qid   = cmd_qid;
  assign rtr_fetch_req  = fetch_go;
  assign rtr_fetch_line = sel_line;
  assign rtr_fetch_qid  = cmd_qid;
  assign rtr_fetch_core = CORE_W'(CORE_ID);
  assign hold_ctx       = pend_any;

  always_comb begin
    done_valid_nx = (is_push && !push_go) || is_fetch;
    done_code_nx  = ST_OK;
    if (!sel_vld)     done_code_nx = ST_NOSEL;
    else if (is_push) done_code_nx = ST_LBUSY;
    else if (!rtr_fetch_room) done_code_nx = ST_RFULL;
  end

  assign pd_code_ok = rtr_push_ok;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      done_valid      <= 1'b0;
      done_code       <= ST_OK;
      push_done_valid <= 1'b0;
      push_done_code  <= ST_OK;
      zero_valid      <= 1'b0;
      zero_line       <= '0;
      inj_ack         <= 1'b0;
      inj_nack        <= 1'b0;
      wr_valid        <= 1'b0;
      wr_line         <= '0;
      wr_data         <= '0;
    end else begin
      done_valid      <= done_valid_nx;
      push_done_valid <= pop_go;
      zero_valid      <= pop_go && pd_code_ok;
      inj_ack         <= inj_hit;
      inj_nack        <= inj_valid && !inj_hit;
      wr_valid        <= inj_hit;
      if (done_valid_nx) done_code <= done_code_nx;
      if (pop_go) begin
        push_done_code <= pd_code_ok ? ST_OK : ST_RFULL;
        zero_line      <= pend_head;
      end
      if (inj_hit) begin
        wr_line <= inj_line;
        wr_data <= inj_data;
      end
    end
  end
endmodule

// File: rtl/ep_sel_chk.sv
module ep_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done_valid,
  input logic [1:0] done_code,
  input logic       rtr_push_req,
  input logic       rtr_push_rsp,
  input logic       push_done_valid,
  input logic [1:0] push_done_code,
  input logic       zero_valid,
  input logic       rtr_fetch_req,
  input logic       inj_valid,
  input logic       inj_ack,
  input logic       inj_nack,
  input logic       wr_valid,
  input logic       hold_ctx
);
  p_push_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rtr_push_req |=> !done_valid);

  p_nosel_noreq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_code == 2'd1) |-> $past(!rtr_push_req && !rtr_fetch_req));

  p_rsp_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rtr_push_rsp && hold_ctx) |=> push_done_valid);

  p_zero_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_valid |-> (push_done_valid && push_done_code == 2'd0));

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rtr_push_req |=> hold_ctx);

  p_fetch_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rtr_fetch_req |=> (done_valid && done_code == 2'd0));

  p_inj_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |=> (inj_ack != inj_nack));

  p_wr_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> inj_ack);
endmodule

bind ep_sel_ctrl ep_sel_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .done_valid      (done_valid),
  .done_code       (done_code),
  .rtr_push_req    (rtr_push_req),
  .rtr_push_rsp    (rtr_push_rsp),
  .push_done_valid (push_done_valid),
  .push_done_code  (push_done_code),
  .zero_valid      (zero_valid),
  .rtr_fetch_req   (rtr_fetch_req),
  .inj_valid       (inj_valid),
  .inj_ack         (inj_ack),
  .inj_nack        (inj_nack),
  .wr_valid        (wr_valid),
  .hold_ctx        (hold_ctx)
);

// File: tb/sim_ep_sel_ctrl.sv
module sim_ep_sel_ctrl;
  localparam int PA_W = 40, LA_W = 34, QID_W = 4, CORE_W = 4, DATA_W = 512;
  localparam int CORE = 5;
  localparam logic [1:0] SEL = 2'b01, PSH = 2'b10, FCH = 2'b11, NOP = 2'b00;

  logic clk, rst_n;
  logic cmd_valid; logic [1:0] cmd_op; logic [PA_W-1:0] cmd_addr; logic [QID_W-1:0] cmd_qid;
  logic done_valid; logic [1:0] done_code;
  logic rtr_push_req; logic [LA_W-1:0] rtr_push_line; logic [QID_W-1:0] rtr_push_qid;
  logic rtr_push_rsp, rtr_push_ok;
  logic push_done_valid; logic [1:0] push_done_code;
  logic zero_valid; logic [LA_W-1:0] zero_line;
  logic rtr_fetch_req; logic [LA_W-1:0] rtr_fetch_line; logic [QID_W-1:0] rtr_fetch_qid;
  logic [CORE_W-1:0] rtr_fetch_core; logic rtr_fetch_room;
  logic inj_valid; logic [LA_W-1:0] inj_line; logic [DATA_W-1:0] inj_data;
  logic inj_ack, inj_nack, wr_valid; logic [LA_W-1:0] wr_line; logic [DATA_W-1:0] wr_data;
  logic ctx_switch, page_migr, evict_valid; logic [LA_W-1:0] evict_line;
  logic hold_ctx;

  ep_sel_ctrl u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  logic cap_preq, cap_freq;
  logic [LA_W-1:0] cap_pline, cap_fline;
  logic [QID_W-1:0] cap_pqid, cap_fqid;
  logic [CORE_W-1:0] cap_fcore;

  typedef struct packed {
    logic [1:0]  op;
    logic [39:0] addr;
    logic [3:0]  qid;
    logic        room;
    logic        e_done;
    logic [1:0]  e_code;
    logic        e_preq;
    logic        e_freq;
  } vec_t;

  localparam logic [39:0] ADDR_A = {30'h0012345, 4'h9, 6'h00};
  localparam logic [39:0] ADDR_B = {30'h00ABCDE, 4'h2, 6'h00};

  localparam vec_t TBL [12] = '{
    '{PSH, ADDR_A, 4'd1, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0},
    '{FCH, ADDR_A, 4'd1, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0},
    '{SEL, ADDR_A, 4'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
    '{PSH, ADDR_A, 4'd3, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0},
    '{PSH, ADDR_A, 4'd3, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0},
    '{SEL, ADDR_B, 4'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
    '{FCH, ADDR_B, 4'd5, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0},
    '{FCH, ADDR_B, 4'd5, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0},
    '{SEL, ADDR_B, 4'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
    '{FCH, ADDR_B, 4'd5, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1},
    '{NOP, ADDR_B, 4'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},
    '{PSH, ADDR_B, 4'd2, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0}
  };

  function automatic logic [39:0] mk(input logic [3:0] idx, input logic [29:0] hi);
    return {hi, idx, 6'h00};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [39:0] addr,
                        input logic [3:0] qid, input logic room);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_qid = qid; rtr_fetch_room = room;
    #2;
    cap_preq = rtr_push_req; cap_pline = rtr_push_line; cap_pqid = rtr_push_qid;
    cap_freq = rtr_fetch_req; cap_fline = rtr_fetch_line; cap_fqid = rtr_fetch_qid;
    cap_fcore = rtr_fetch_core;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; cmd_op = NOP; rtr_fetch_room = 1'b1;
  endtask

  task automatic do_inj(input logic [LA_W-1:0] line, input logic [DATA_W-1:0] data);
    inj_valid = 1'b1; inj_line = line; inj_data = data;
    @(posedge clk); @(negedge clk);
    inj_valid = 1'b0;
  endtask

  task automatic do_rsp(input logic ok);
    rtr_push_rsp = 1'b1; rtr_push_ok = ok;
    @(posedge clk); @(negedge clk);
    rtr_push_rsp = 1'b0; rtr_push_ok = 1'b0;
  endtask

  task automatic pulse_ctx(input bit ctx, input bit pm);
    ctx_switch = ctx; page_migr = pm;
    @(posedge clk); @(negedge clk);
    ctx_switch = 1'b0; page_migr = 1'b0;
  endtask

  task automatic pulse_evict(input logic [LA_W-1:0] line);
    evict_valid = 1'b1; evict_line = line;
    @(posedge clk); @(negedge clk);
    evict_valid = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [39:0] pa [4];
    rst_n = 1'b0; cmd_valid = 0; cmd_op = NOP; cmd_addr = '0; cmd_qid = '0;
    rtr_push_rsp = 0; rtr_push_ok = 0; rtr_fetch_room = 1; inj_valid = 0;
    inj_line = '0; inj_data = '0; ctx_switch = 0; page_migr = 0;
    evict_valid = 0; evict_line = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 done_valid", done_valid, 0);
    chk("R1 push_done_valid", push_done_valid, 0);
    chk("R1 zero_valid", zero_valid, 0);
    chk("R1 inj_ack", inj_ack, 0);
    chk("R1 inj_nack", inj_nack, 0);
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 hold_ctx", hold_ctx, 0);

    // table walk: R2 R3 R4 R7
    for (int i = 0; i < 12; i++) begin
      string t;
      t = TBL[i].e_preq ? "R2" : TBL[i].e_freq ? "R7" :
          (TBL[i].e_code == 2'd2) ? "R7" : TBL[i].e_done ? "R3" : "R2";
      do_cmd(TBL[i].op, TBL[i].addr, TBL[i].qid, TBL[i].room);
      chk($sformatf("%s vec%0d push_req", t, i), cap_preq, TBL[i].e_preq);
      chk($sformatf("%s vec%0d fetch_req", t, i), cap_freq, TBL[i].e_freq);
      if (TBL[i].e_preq) begin
        chk("R2 push_line", cap_pline, TBL[i].addr[39:6]);
        chk("R2 push_qid", cap_pqid, TBL[i].qid);
      end
      if (TBL[i].e_freq) begin
        chk("R7 fetch_line", cap_fline, TBL[i].addr[39:6]);
        chk("R7 fetch_qid", cap_fqid, TBL[i].qid);
        chk("R7 fetch_core", cap_fcore, CORE);
      end
      chk($sformatf("%s vec%0d done_valid", t, i), done_valid, TBL[i].e_done);
      if (TBL[i].e_done) chk($sformatf("%s vec%0d done_code", t, i), done_code, TBL[i].e_code);
    end

    // R6 one push pending from the table
    chk("R6 hold while pending", hold_ctx, 1);
    // R5 success answer zeroes line A
    do_rsp(1'b1);
    chk("R5 push_done_valid", push_done_valid, 1);
    chk("R5 push_done_code ok", push_done_code, 0);
    chk("R5 zero_valid", zero_valid, 1);
    chk("R5 zero_line", zero_line, ADDR_A[39:6]);
    chk("R6 hold released", hold_ctx, 0);

    // R8 injection into fetched line B
    do_inj(ADDR_B[39:6], {16{32'hA5A5_0001}});
    chk("R8 inj_ack", inj_ack, 1);
    chk("R8 wr_valid", wr_valid, 1);
    chk("R8 wr_line", wr_line, ADDR_B[39:6]);
    chk("R8 wr_data", wr_data[63:0], {2{32'hA5A5_0001}});
    do_inj(ADDR_B[39:6], {16{32'hA5A5_0002}});
    chk("R8 second inj nack", inj_nack, 1);
    chk("R8 second inj no write", wr_valid, 0);

    // R9 never-fetched line
    do_inj(mk(4'hA, 30'h33)>>6, {16{32'h1}});
    chk("R9 inj_nack", inj_nack, 1);
    chk("R9 inj_ack low", inj_ack, 0);
    chk("R9 wr_valid low", wr_valid, 0);

    // R7 refused fetch sets no flag
    do_cmd(SEL, mk(4'h8, 30'h12), 0, 1);
    do_cmd(FCH, mk(4'h8, 30'h12), 1, 0);
    chk("R7 room low code", done_code, 2);
    do_inj(mk(4'h8, 30'h12)>>6, '1);
    chk("R7 no flag after refusal", inj_nack, 1);

    // R5 failed push keeps line
    do_cmd(SEL, mk(4'h1, 30'h44), 0, 1);
    do_cmd(PSH, mk(4'h1, 30'h44), 2, 1);
    chk("R5 fail push req", cap_preq, 1);
    do_rsp(1'b0);
    chk("R5 fail push_done_valid", push_done_valid, 1);
    chk("R5 fail code", push_done_code, 2);
    chk("R5 fail no zero", zero_valid, 0);

    // R6 fill the pending tracker
    for (int k = 0; k < 4; k++) begin
      pa[k] = mk(4'(k), 30'(32'h100 + k));
      do_cmd(SEL, pa[k], 0, 1);
      do_cmd(PSH, pa[k], 4'(k), 1);
      chk("R6 fill push req", cap_preq, 1);
    end
    chk("R6 hold full", hold_ctx, 1);
    do_cmd(SEL, mk(4'hF, 30'h200), 0, 1);
    do_cmd(PSH, mk(4'hF, 30'h200), 1, 1);
    chk("R6 busy no req", cap_preq, 0);
    chk("R6 busy done_valid", done_valid, 1);
    chk("R6 busy code", done_code, 3);
    // R4 latch consumed by the refused push
    do_cmd(PSH, mk(4'hF, 30'h200), 1, 1);
    chk("R4 consumed latch code", done_code, 1);
    chk("R4 consumed latch no req", cap_preq, 0);
    // R11 answers in issue order
    for (int k = 0; k < 4; k++) begin
      do_rsp(1'b1);
      chk("R11 zero_valid", zero_valid, 1);
      chk("R11 zero_line order", zero_line, pa[k][39:6]);
    end
    chk("R6 hold drained", hold_ctx, 0);

    // R10 page migration keeps flag, clears latch
    do_cmd(SEL, mk(4'h3, 30'h7), 0, 1);
    do_cmd(FCH, mk(4'h3, 30'h7), 1, 1);
    chk("R10 fetch D ok", done_code, 0);
    pulse_ctx(1'b0, 1'b1);
    do_cmd(PSH, mk(4'h3, 30'h7), 1, 1);
    chk("R10 page_migr clears latch", done_code, 1);
    do_inj(mk(4'h3, 30'h7)>>6, '0);
    chk("R10 page_migr keeps flag", inj_ack, 1);

    // R10 eviction clears one flag only
    do_cmd(SEL, mk(4'h4, 30'h8), 0, 1);
    do_cmd(FCH, mk(4'h4, 30'h8), 1, 1);
    do_cmd(SEL, mk(4'h5, 30'h9), 0, 1);
    do_cmd(FCH, mk(4'h5, 30'h9), 1, 1);
    pulse_evict(mk(4'h4, 30'h8)>>6);
    do_inj(mk(4'h4, 30'h8)>>6, '0);
    chk("R10 evicted line nack", inj_nack, 1);
    do_inj(mk(4'h5, 30'h9)>>6, '0);
    chk("R10 other line ack", inj_ack, 1);

    // R10 context switch clears flags and latch
    do_cmd(SEL, mk(4'h6, 30'hA), 0, 1);
    do_cmd(FCH, mk(4'h6, 30'hA), 1, 1);
    do_cmd(SEL, mk(4'h7, 30'hB), 0, 1);
    pulse_ctx(1'b1, 1'b0);
    do_cmd(PSH, mk(4'h7, 30'hB), 1, 1);
    chk("R10 ctx clears latch", done_code, 1);
    chk("R10 ctx no push req", cap_preq, 0);
    do_inj(mk(4'h6, 30'hA)>>6, '0);
    chk("R10 ctx clears flag", inj_nack, 1);

    summary();
  end
endmodule